// File: doc/BRIEF.md
# Masked Address Window Remapper

This block sits between a host firmware-space port and a 32-bit internal bus. It decides whether an incoming host address falls inside one programmable window and, if it does, rewrites the address for the internal bus. Both the decode and the rewrite act only on the upper half of the address. The lower half is always copied through as it is.

The window is set by two configuration words. The bases word holds the remap base in its upper half and the match base in its lower half. The masks word holds the remap mask in its upper half and the don't-care mask in its lower half.

The decode is a compare, bit by bit, against the match base, and the don't-care mask can exclude any bit from that compare. The rewrite is a mux for each bit: where the remap mask is set, the output bit comes from the remap base, and elsewhere it comes from the incoming address. This lets power-of-two regions of any size and alignment be moved, with no adder and no magnitude comparator. The result is registered for one cycle and travels with the request's write flag and tag. A downstream request strobe is raised only for a hit.

Top module: `addr_window_remap`

## Requirements
- R1: After reset both configuration words are zero. A request whose upper half is 0x0000 then hits and passes through unchanged, and any other upper half misses.
- R2: A write with cfgSel=0 loads the bases word: remap base from cfgWrData[31:16] and match base from cfgWrData[15:0]. A write with cfgSel=1 loads the masks word: remap mask from cfgWrData[31:16] and don't-care mask from cfgWrData[15:0].
- R3: A request hits exactly when every upper address bit whose don't-care bit is 0 equals the corresponding match-base bit. Upper address bits whose don't-care bit is 1 have no effect on the hit.
- R4: On a hit, output bit 16+i is taken from remap-base bit i when remap-mask bit i is 1, and from address bit 16+i when it is 0.
- R5: Output address bits [15:0] always equal request address bits [15:0], for a hit and for a miss.
- R6: rspValid, rspHit, rspAddr, rspWrite and rspTag show a request in the cycle after the clock edge that samples reqValid=1. rspWrite and rspTag copy reqWrite and reqTag.
- R7: A request that misses gives rspValid=1 with rspHit=0 and busReq=0. A hit gives busReq=1.
- R8: A configuration write takes effect for requests sampled on later clock edges. A request sampled on the same edge as the write is translated with the previous configuration.
- R9: Across an edge that samples reqValid=0, the block presents rspValid=0 and busReq=0 on the following cycle.
- R10: With match base 0xFCE0, don't-care 0x001F, remap base 0x3000 and remap mask 0xFFE0, host addresses 0xFCE00000 to 0xFCFFFFFF map onto 0x30000000 to 0x301FFFFF. With match base 0x0E00, don't-care 0x01FF, remap base 0x3000 and remap mask 0xFE00, host addresses 0x0E000000 to 0x0FFFFFFF map onto 0x30000000 to 0x31FFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Configuration write enable |
| cfgSel | input | 1 | Selects the word: 0 is the bases word, 1 is the masks word |
| cfgWrData | input | ADDR_W | Configuration write data |
| reqValid | input | 1 | A host request is present |
| reqAddr | input | ADDR_W | Host firmware-space address |
| reqWrite | input | 1 | Request direction qualifier |
| reqTag | input | TAG_W | Request tag qualifier |
| rspValid | output | 1 | A translated result is present |
| rspHit | output | 1 | The address fell in the window |
| busReq | output | 1 | Downstream request strobe, raised on a hit only |
| rspAddr | output | ADDR_W | Translated address |
| rspWrite | output | 1 | Registered copy of reqWrite |
| rspTag | output | TAG_W | Registered copy of reqTag |

## Verification
The bench builds the block with its default parameters: a 32-bit address, which gives 16-bit windows, and a 4-bit tag. At this size the upper half of the address can be swept at fine steps across both example windows. The expected hit range and the expected offset are worked out by arithmetic and checked at the window edges. A generated set of mask and base combinations tests the rule for each bit on its own, with zero masks and all-ones masks included. Further directed requests test the reset mapping, the write ordering against a request on the same edge, the idle cycles and the carrying of the write flag and tag.

// File: rtl/awr_pkg.sv
package awr_pkg;

  typedef enum logic {
    CFG_BASES = 1'b0,
    CFG_MASKS = 1'b1
  } cfg_sel_e;

  typedef struct packed {
    logic capture;
    logic wrBases;
    logic wrMasks;
  } ctl_strobe_t;

endpackage

// File: rtl/awr_control.sv
module awr_control
  import awr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfgWrEn,
  input  logic        cfgSel,
  input  logic        reqValid,
  output ctl_strobe_t ctl
);

  cfg_sel_e selWord;

  always_comb begin
    selWord     = cfg_sel_e'(cfgSel);
    ctl.capture = reqValid;
    ctl.wrBases = cfgWrEn && (selWord == CFG_BASES);
    ctl.wrMasks = cfgWrEn && (selWord == CFG_MASKS);
  end

  // R2: a single write never loads both words
  p_single_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.wrBases, ctl.wrMasks}));

endmodule

// File: rtl/awr_datapath.sv
module awr_datapath
  import awr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_strobe_t       ctl,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [TAG_W-1:0]  reqTag,
  output logic              rspValid,
  output logic              rspHit,
  output logic              busReq,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              rspWrite,
  output logic [TAG_W-1:0]  rspTag
);

  localparam int HALF_W = ADDR_W / 2;

  logic [HALF_W-1:0] remapBase, matchBase, remapMask, dontCare;
  logic [HALF_W-1:0] bitOk, hiOut;
  logic              winHit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remapBase <= '0;
      matchBase <= '0;
      remapMask <= '0;
      dontCare  <= '0;
    end else begin
      if (ctl.wrBases) begin
        remapBase <= cfgWrData[ADDR_W-1:HALF_W];
        matchBase <= cfgWrData[HALF_W-1:0];
      end
      if (ctl.wrMasks) begin
        remapMask <= cfgWrData[ADDR_W-1:HALF_W];
        dontCare  <= cfgWrData[HALF_W-1:0];
      end
    end
  end

  for (genvar i = 0; i < HALF_W; i++) begin : g_bit
    assign bitOk[i] = dontCare[i] | ~(reqAddr[HALF_W+i] ^ matchBase[i]);
    assign hiOut[i] = remapMask[i] ? remapBase[i] : reqAddr[HALF_W+i];
  end

  assign winHit = &bitOk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      busReq   <= 1'b0;
      rspAddr  <= '0;
      rspWrite <= 1'b0;
      rspTag   <= '0;
    end else begin
      rspValid <= ctl.capture;
      busReq   <= ctl.capture && winHit;
      if (ctl.capture) begin
        rspHit   <= winHit;
        rspAddr  <= {hiOut, reqAddr[HALF_W-1:0]};
        rspWrite <= reqWrite;
        rspTag   <= reqTag;
      end
    end
  end

  // R7: strobe only with a valid hit
  p_strobe_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busReq |-> (rspValid && rspHit));

  // R9: idle input gives quiet output
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.capture |=> (!rspValid && !busReq));

  // R5: low half copied straight
  p_low_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.capture |=> (rspAddr[HALF_W-1:0] == $past(reqAddr[HALF_W-1:0])));

  // R6: qualifiers follow the request
  p_qual_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.capture |=> (rspWrite == $past(reqWrite) && rspTag == $past(reqTag)));

  // R4: a zero remap mask leaves the address untouched
  p_zero_mask_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.capture && remapMask == '0) |=> (rspAddr == $past(reqAddr)));

  // R8: configuration holds without a write
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.wrBases && !ctl.wrMasks) |=>
      ($stable(remapBase) && $stable(matchBase) &&
       $stable(remapMask) && $stable(dontCare)));

endmodule

// File: rtl/addr_window_remap.sv
module addr_window_remap
  import awr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [TAG_W-1:0]  reqTag,
  output logic              rspValid,
  output logic              rspHit,
  output logic              busReq,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              rspWrite,
  output logic [TAG_W-1:0]  rspTag
);

  ctl_strobe_t ctl;

  awr_control u_control (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfgWrEn  (cfgWrEn),
    .cfgSel   (cfgSel),
    .reqValid (reqValid),
    .ctl      (ctl)
  );

  awr_datapath #(
    .ADDR_W (ADDR_W),
    .TAG_W  (TAG_W)
  ) u_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .cfgWrData (cfgWrData),
    .reqAddr   (reqAddr),
    .reqWrite  (reqWrite),
    .reqTag    (reqTag),
    .rspValid  (rspValid),
    .rspHit    (rspHit),
    .busReq    (busReq),
    .rspAddr   (rspAddr),
    .rspWrite  (rspWrite),
    .rspTag    (rspTag)
  );

endmodule

// File: tb/addr_window_remap_bench.sv
module addr_window_remap_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int TAG_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfgWrEn = 1'b0;
  logic              cfgSel = 1'b0;
  logic [ADDR_W-1:0] cfgWrData = '0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqWrite = 1'b0;
  logic [TAG_W-1:0]  reqTag = '0;
  logic              rspValid, rspHit, busReq, rspWrite;
  logic [ADDR_W-1:0] rspAddr;
  logic [TAG_W-1:0]  rspTag;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit ended   = 1'b0;

  addr_window_remap #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_addr_window_remap (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqTag(reqTag), .rspValid(rspValid),
    .rspHit(rspHit), .busReq(busReq), .rspAddr(rspAddr),
    .rspWrite(rspWrite), .rspTag(rspTag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
    finishRun();
  end

  task automatic writeCfg(input logic sel, input logic [31:0] data);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = data;
    @(posedge clk); #1;
    cfgWrEn = 1'b0;
  endtask

  task automatic checkRsp(input logic [31:0] a, input logic w, input logic [3:0] t,
                          input logic expHit, input logic [31:0] expAddr, input string req);
    nChecks++;
    if (rspValid !== 1'b1 || rspHit !== expHit || busReq !== expHit ||
        rspWrite !== w || rspTag !== t || rspAddr[15:0] !== a[15:0] ||
        (expHit && rspAddr !== expAddr)) begin
      nFails++;
      $display("FAIL %s addr=%h: actual v=%b hit=%b req=%b a=%h w=%b t=%h expected hit=%b a=%h w=%b t=%h",
               req, a, rspValid, rspHit, busReq, rspAddr, rspWrite, rspTag,
               expHit, expAddr, w, t);
    end
  endtask

  task automatic doReq(input logic [31:0] a, input logic w, input logic [3:0] t,
                       input logic expHit, input logic [31:0] expAddr, input string req);
    reqValid = 1'b1; reqAddr = a; reqWrite = w; reqTag = t;
    @(posedge clk); #1;
    reqValid = 1'b0;
    checkRsp(a, w, t, expHit, expAddr, req);
  endtask

  task automatic checkIdle(input string req);
    @(posedge clk); #1;
    nChecks++;
    if (rspValid !== 1'b0 || busReq !== 1'b0) begin
      nFails++;
      $display("FAIL %s: actual v=%b req=%b expected v=0 req=0", req, rspValid, busReq);
    end
  endtask

  // R10: expected values from the window range and an offset add
  task automatic sweepExample(input logic [15:0] lo, input logic [15:0] hi, input string req);
    logic [15:0] edges [4];
    edges[0] = lo - 16'd1; edges[1] = lo; edges[2] = hi; edges[3] = hi + 16'd1;
    for (int u = 0; u < 65536; u += 3) begin
      logic [31:0] a;
      logic inWin;
      a = {u[15:0], u[15:0] ^ 16'h5A3C};
      inWin = (u >= lo) && (u <= hi);
      doReq(a, u[0], u[3:0], inWin, {16'h3000 + (u[15:0] - lo), a[15:0]}, req);
    end
    for (int e = 0; e < 4; e++) begin
      logic [31:0] a;
      a = {edges[e], 16'hFFFF};
      doReq(a, 1'b1, 4'hA, (edges[e] >= lo) && (edges[e] <= hi),
            {16'h3000 + (edges[e] - lo), 16'hFFFF}, req);
    end
  endtask

  initial begin
    logic [31:0] lcg;
    repeat (3) @(posedge clk);
    #1;
    // R9 / R1 reset state at the ports
    nChecks++;
    if (rspValid !== 1'b0 || busReq !== 1'b0 || rspHit !== 1'b0) begin
      nFails++;
      $display("FAIL R1 reset: actual v=%b hit=%b req=%b expected 0 0 0", rspValid, rspHit, busReq);
    end
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: zero configuration
    doReq(32'h0000_1234, 1'b0, 4'h1, 1'b1, 32'h0000_1234, "R1 zero-cfg hit");
    doReq(32'h0001_0000, 1'b1, 4'h2, 1'b0, 32'h0, "R1 zero-cfg miss low bit");
    doReq(32'h8000_ABCD, 1'b0, 4'h3, 1'b0, 32'h0, "R1 zero-cfg miss high bit");
    checkIdle("R9 idle after request");
    checkIdle("R9 idle repeated");

    // R2 field placement, R10 first example
    writeCfg(1'b0, 32'h3000_FCE0);
    writeCfg(1'b1, 32'hFFE0_001F);
    sweepExample(16'hFCE0, 16'hFCFF, "R10 example one");

    // R10 second example
    writeCfg(1'b0, 32'h3000_0E00);
    writeCfg(1'b1, 32'hFE00_01FF);
    sweepExample(16'h0E00, 16'h0FFF, "R10 example two");

    // R3 / R4 / R7: generated configurations, bitwise rule
    lcg = 32'h1234_5678;
    for (int c = 0; c < 64; c++) begin
      logic [15:0] mb, dc, rb, rm;
      lcg = lcg * 32'd1664525 + 32'd1013904223; mb = lcg[31:16];
      lcg = lcg * 32'd1664525 + 32'd1013904223; dc = lcg[31:16] & lcg[15:0];
      lcg = lcg * 32'd1664525 + 32'd1013904223; rb = lcg[31:16];
      lcg = lcg * 32'd1664525 + 32'd1013904223; rm = lcg[15:0];
      if (c == 0) begin dc = 16'h0000; rm = 16'h0000; end
      if (c == 1) begin dc = 16'hFFFF; rm = 16'hFFFF; end
      writeCfg(1'b0, {rb, mb});
      writeCfg(1'b1, {rm, dc});
      for (int k = 0; k < 64; k++) begin
        logic [15:0] u;
        logic [31:0] a;
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        // half the probes keep the cared bits equal to the match base
        u = k[0] ? ((mb & ~dc) | (lcg[31:16] & dc)) : lcg[31:16];
        a = {u, lcg[15:0]};
        doReq(a, k[1], k[5:2], ((u ^ mb) & ~dc) == 16'h0,
              {(u & ~rm) | (rb & rm), a[15:0]}, "R3 R4 R7 bitwise rule");
      end
    end

    // R8: write and request on the same edge
    writeCfg(1'b0, 32'h1111_0000);
    writeCfg(1'b1, 32'hFFFF_FFFF);
    cfgWrEn = 1'b1; cfgSel = 1'b0; cfgWrData = 32'h2222_0000;
    reqValid = 1'b1; reqAddr = 32'hABCD_0001; reqWrite = 1'b1; reqTag = 4'h7;
    @(posedge clk); #1;
    cfgWrEn = 1'b0; reqValid = 1'b0;
    checkRsp(32'hABCD_0001, 1'b1, 4'h7, 1'b1, 32'h1111_0001, "R8 same-edge uses old cfg");
    doReq(32'hABCD_0001, 1'b0, 4'h8, 1'b1, 32'h2222_0001, "R8 next request uses new cfg");

    // R2: masks-word write leaves the bases word in place
    writeCfg(1'b1, 32'h0000_0000);
    doReq(32'h0000_5555, 1'b0, 4'h9, 1'b1, 32'h0000_5555, "R2 masks zero match base 0000");
    doReq(32'h2222_5555, 1'b0, 4'h9, 1'b0, 32'h0, "R2 bases word kept after masks write");
    checkIdle("R9 final idle");

    finishRun();
  end

endmodule